// File: doc/BRIEF.md
# Scalar Float32 Minimum Unit

This unit takes two 128-bit vector sources and compares only their low 32-bit lanes, each read as a single-precision float. It writes the smaller value to the low 32 bits of a 256-bit destination. The choice is deliberately asymmetric. When both lanes are zero, or when either lane is a NaN, the second source lane goes through unchanged, bit for bit. A signalling NaN is never quieted. Two equal values also give the second source.

A mode input chooses how the upper destination bits are formed. In preserve mode, bits 255 to 32 come from the previous destination contents. In three-operand mode, bits 127 to 32 are copied from the first source and bits 255 to 128 are cleared.

The unit also raises an invalid flag when either lane is a NaN, quiet NaNs included. It raises a denormal flag when either lane is subnormal. A parameter adds an output register. With the register, results and flags appear one cycle after the input strobe, together with an output valid.

Top module: `f32_min_unit`

## Requirements
- R1: The result in dest[31:0] is always either src_a[31:0] or src_b[31:0]. No other source bits take part in the compare.
- R2: If both lanes are zero (bits 30:0 all zero), the result is src_b[31:0] exactly, whatever the two sign bits (bit 31) are.
- R3: If either lane is a NaN (bits 30:23 all ones and bits 22:0 non-zero), the result is src_b[31:0]. This holds whether the NaN is in the first lane, the second lane or both.
- R4: A signalling NaN (bit 22 clear) in the second lane is returned with its exact pattern, with bit 22 still clear.
- R5: Otherwise the result is src_a[31:0] only if it is strictly less than src_b[31:0]; on equality it is src_b. The order is as follows:
  - A negative non-zero value is below every positive value.
  - Two positive values are ordered by their bits 30:0.
  - Two negative values are ordered by their bits 30:0 in reverse.
  - Infinities follow the same rules.
- R6: With mode = 0 (preserve), dest[255:32] equals old_dest[255:32].
- R7: With mode = 1 (three-operand), dest[127:32] equals src_a[127:32] and dest[255:128] is zero.
- R8: flag_invalid is 1 exactly when either lane is a NaN, quiet or signalling.
- R9: flag_denormal is 1 exactly when either lane is subnormal (bits 30:23 zero, bits 22:0 non-zero).
- R10: With the output register present, out_valid is 1 exactly in the cycle after a cycle with in_valid = 1. dest and the flags then show the result for that input. A synchronous active-high reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| mode | input | 1 | 0 = preserve upper bits, 1 = three-operand merge |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| old_dest | input | 256 | Previous destination contents |
| out_valid | output | 1 | Result valid |
| dest | output | 256 | Merged destination |
| flag_invalid | output | 1 | A lane is a NaN |
| flag_denormal | output | 1 | A lane is subnormal |

## Verification
The hardest cases to reach are those where the asymmetric rule differs from an ordinary minimum. One is a NaN in the first lane only, paired with a number that is plainly smaller. Another is a pair of zeros whose signs are swapped. The stimulus covers both operand orders for each of these cases. It also sends a signalling NaN with a non-trivial payload in the second lane, so that any quieting of bit 22 shows up in the result. These operand patterns are streamed back to back in both merge modes, with distinct upper-bit contents in old_dest and src_a, so that a mixed-up merge source cannot hide.

// File: rtl/f32_min_unit.sv
module f32_min_unit #(
  parameter bit REGISTER_OUT = 1'b1,
  parameter int VEC_W  = 128,
  parameter int DEST_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [DEST_W-1:0] old_dest,
  output logic              out_valid,
  output logic [DEST_W-1:0] dest,
  output logic              flag_invalid,
  output logic              flag_denormal
);
  localparam int LANE_W = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int HI_W   = DEST_W - LANE_W;
  localparam int TOP_W  = DEST_W - VEC_W;

  logic [LANE_W-1:0] a, b;
  assign a = src_a[LANE_W-1:0];
  assign b = src_b[LANE_W-1:0];

  logic a_nan, b_nan, a_zero, b_zero, a_sub, b_sub;
  assign a_nan  = (&a[LANE_W-2:MAN_W]) && (|a[MAN_W-1:0]);
  assign b_nan  = (&b[LANE_W-2:MAN_W]) && (|b[MAN_W-1:0]);
  assign a_zero = ~|a[LANE_W-2:0];
  assign b_zero = ~|b[LANE_W-2:0];
  assign a_sub  = (~|a[LANE_W-2:MAN_W]) && (|a[MAN_W-1:0]);
  assign b_sub  = (~|b[LANE_W-2:MAN_W]) && (|b[MAN_W-1:0]);

  logic a_less;
  always_comb begin
    if (a[LANE_W-1] != b[LANE_W-1])
      a_less = a[LANE_W-1];
    else if (!a[LANE_W-1])
      a_less = a[LANE_W-2:0] < b[LANE_W-2:0];
    else
      a_less = a[LANE_W-2:0] > b[LANE_W-2:0];
  end

  logic take_a;
  assign take_a = a_less && !(a_zero && b_zero) && !a_nan && !b_nan;

  logic [HI_W-1:0] upper;
  assign upper = mode ? {{TOP_W{1'b0}}, src_a[VEC_W-1:LANE_W]}
                      : old_dest[DEST_W-1:LANE_W];

  logic [DEST_W-1:0] next_dest;
  assign next_dest = {upper, take_a ? a : b};

  generate
    if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
        if (in_valid) begin
          dest          <= next_dest;
          flag_invalid  <= a_nan || b_nan;
          flag_denormal <= a_sub || b_sub;
        end
      end

      assert_one_source_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (dest[31:0] == $past(src_a[31:0])) || (dest[31:0] == $past(src_b[31:0])));
      assert_zero_pair_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && src_a[30:0] == 31'd0 && src_b[30:0] == 31'd0 |=> dest[31:0] == $past(src_b[31:0]));
      assert_nan_second_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && ((src_a[30:23] == 8'hFF && src_a[22:0] != 23'd0) ||
                     (src_b[30:23] == 8'hFF && src_b[22:0] != 23'd0))
        |=> dest[31:0] == $past(src_b[31:0]) && flag_invalid);
      assert_preserve_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && !mode |=> dest[DEST_W-1:32] == $past(old_dest[DEST_W-1:32]));
      assert_clear_top_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && mode |=> dest[DEST_W-1:VEC_W] == '0 && dest[VEC_W-1:32] == $past(src_a[VEC_W-1:32]));
      assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    end else begin : g_comb
      assign out_valid     = in_valid;
      assign dest          = next_dest;
      assign flag_invalid  = a_nan || b_nan;
      assign flag_denormal = a_sub || b_sub;
    end
  endgenerate
endmodule

// File: tb/f32_min_unit_tb.sv
module f32_min_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic mode = 1'b0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [255:0] old_dest = '0;
  logic out_valid;
  logic [255:0] dest;
  logic flag_invalid, flag_denormal;

  always #5 clk = ~clk;

  f32_min_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .src_a(src_a), .src_b(src_b), .old_dest(old_dest),
    .out_valid(out_valid), .dest(dest),
    .flag_invalid(flag_invalid), .flag_denormal(flag_denormal));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [257:0] exp_q[$];
  string tag_q[$];

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
  localparam logic [31:0] M_ONE = 32'hBF80_0000, M_TWO = 32'hC000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_1234, SNAN = 32'h7F80_5A5A;
  localparam logic [31:0] SUB = 32'h0000_0007, M_SUB = 32'h8000_0100;

  function automatic bit is_nan(logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic bit is_sub(logic [31:0] x);
    return x[30:23] == 8'h00 && x[22:0] != 0;
  endfunction
  function automatic logic [31:0] order_key(logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(string tag, logic [31:0] a, logic [31:0] b, logic m);
    logic [31:0] r;
    logic [255:0] d;
    logic [127:0] va, vb;
    logic [255:0] od;
    va = {32'hA5A5_0000 ^ a, 32'h1357_9BDF, 32'h0F0F_F0F0, a};
    vb = {32'hDEAD_BEEF, 32'hCAFE_F00D ^ b, 32'h1111_2222, b};
    od = {96'hFEED_0000_1234_5678_9ABC_DEF0, 128'h7777_8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE, 32'h5555_5555};
    if ((a[30:0] == 0 && b[30:0] == 0) || is_nan(a) || is_nan(b)) r = b;
    else if (order_key(a) < order_key(b)) r = a;
    else r = b;
    d = m ? {128'd0, va[127:32], r} : {od[255:32], r};
    exp_q.push_back({is_nan(a) || is_nan(b), is_sub(a) || is_sub(b), d});
    tag_q.push_back(tag);
    @(negedge clk);
    src_a = va; src_b = vb; old_dest = od; mode = m; in_valid = 1'b1;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 actual=out_valid expected=no result");
      end else begin
        logic [257:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, dest, e[255:0]);
        check({t, " R8"}, {255'd0, flag_invalid}, {255'd0, e[257]});
        check({t, " R9"}, {255'd0, flag_denormal}, {255'd0, e[256]});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", {255'd0, out_valid}, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 idle", {255'd0, out_valid}, 256'd0);
    send("R2 +0,-0", PZ, NZ, 1'b0);
    send("R2 -0,+0", NZ, PZ, 1'b0);
    send("R2 -0,-0", NZ, NZ, 1'b1);
    send("R2 +0,+0", PZ, PZ, 1'b1);
    send("R3 nan first", QNAN, M_TWO, 1'b0);
    send("R3 nan second", M_TWO, QNAN, 1'b1);
    send("R3 nan both", SNAN, QNAN, 1'b0);
    send("R4 snan kept", ONE, SNAN, 1'b0);
    send("R4 snan kept m1", SNAN, SNAN ^ 32'h0000_0F00, 1'b1);
    send("R5 equal", TWO, TWO, 1'b0);
    send("R5 less", ONE, TWO, 1'b1);
    send("R5 greater", TWO, ONE, 1'b0);
    send("R5 neg order", M_ONE, M_TWO, 1'b1);
    send("R5 neg order2", M_TWO, M_ONE, 1'b0);
    send("R5 mixed", M_ONE, ONE, 1'b0);
    send("R5 mixed2", ONE, M_ONE, 1'b1);
    send("R5 inf", NINF, PINF, 1'b0);
    send("R5 inf2", PINF, TWO, 1'b1);
    send("R5 -inf", M_TWO, NINF, 1'b0);
    send("R9 sub", SUB, ONE, 1'b0);
    send("R9 negsub", ONE, M_SUB, 1'b1);
    send("R1 zero vs sub", NZ, SUB, 1'b0);
    send("R6 preserve", TWO, M_ONE, 1'b0);
    send("R7 three-op", M_ONE, TWO, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 drained", {255'd0, out_valid}, 256'd0);
    check("R10 queue empty", 256'(exp_q.size()), 256'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule